// File: doc/BRIEF.md
# ADC Conversion-Cycle Power Sequencer

This block sits in the digital core of a successive-approximation converter. It follows each conversion cycle, acquire then convert then back, and moves the analog section between full power, a light nap and a deep power-down. The block runs from one clock. The conversion-start pin, the active-low chip-select pin, an end-of-conversion strobe and single-cycle register write strobes all arrive already synchronous to that clock.

A nap happens between conversions. It is taken when the nap enable is set and the conversion-start pin is still high at the moment the conversion completes. While napping, the auxiliary analog blocks are off and the core stays on. Lowering conversion-start ends the nap and opens a wake-up wait of `NAP_WAKE_CYC` cycles.

Deep power-down is requested through a locked control register and takes effect at the next chip-select rising edge. In deep power-down every analog enable is off, while the register contents and the write path stay alive. Clearing the request opens a power-up wait of `PWRUP_CYC` cycles. A conversion request made during either wait is refused and recorded in a sticky error flag.

States: `ST_ACQ` (acquire), `ST_CNV` (converting), `ST_NAP` (napping), `ST_WAKE` (nap wake-up wait), `ST_PD` (deep power-down), `ST_PWRUP` (power-up wait). Transitions:
- ACQ→PD when the power-down bit is set and chip-select rises. This takes priority over a conversion request.
- ACQ→CNV on a conversion-start rising edge.
- CNV→NAP on end-of-conversion when nap is enabled and conversion-start is high.
- CNV→ACQ on any other end-of-conversion.
- NAP→WAKE on a conversion-start falling edge.
- WAKE→ACQ when the wait expires.
- PD→PWRUP when the power-down bit reads zero.
- PWRUP→ACQ when the wait expires.

Top module: `adc_pwr_seq`

## Requirements
- R1: After synchronous reset the block is in acquire with all outputs at rest: core and auxiliary enables high, ready high, both busy flags low, error flag low. Reset also clears nap enable and power-down and re-locks the control register.
- R2: A conversion-start rising edge in acquire starts a conversion, and ready drives low from the next cycle. Ready stays low until the cycle after the end-of-conversion strobe.
- R3: With nap disabled, end-of-conversion returns the block to acquire whatever the conversion-start level. Ready and both enables are then high.
- R4: With nap enabled and conversion-start high at end-of-conversion, the block naps. In the nap, the auxiliary enable is low, the core enable and ready are high, and this holds as long as conversion-start stays high.
- R5: With nap enabled and conversion-start low at end-of-conversion, the block goes straight back to acquire with no wake-up wait.
- R6: A conversion-start falling edge in the nap raises the wake-up busy flag for exactly NAP_WAKE_CYC cycles. The block then returns to acquire with all enables high.
- R7: The control register sits at address 0x010, with bit 0 as power-down and bit 1 as nap enable. Only the write that immediately follows a write of 0x69 to address 0x011 can change it. Any write in between, to any address, uses up the unlock, and a write to the control register without a fresh unlock has no effect.
- R8: With power-down set, the block enters deep power-down on the next chip-select rising edge, not at the write itself. There, core and auxiliary enables are low and ready is high.
- R9: In deep power-down, a conversion-start edge is ignored without raising the error flag, and the register contents are kept through power-down and power-up.
- R10: Clearing power-down while in deep power-down raises the power-up busy flag for exactly PWRUP_CYC cycles, with ready and core enable high. The block then returns to acquire.
- R11: A conversion-start rising edge during the wake-up or power-up wait sets a sticky error flag and does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| convst_i | input | 1 | Conversion-start pin |
| cs_n_i | input | 1 | Chip select, active low; its rising edge ends a frame |
| eoc_i | input | 1 | End-of-conversion strobe from the converter |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| ana_core_en_o | output | 1 | Enable for all analog blocks, low in deep power-down |
| ana_aux_en_o | output | 1 | Enable for the blocks that nap, low in nap and deep power-down |
| ready_o | output | 1 | Ready status, low only while converting |
| wake_busy_o | output | 1 | Nap wake-up wait in progress |
| pwrup_busy_o | output | 1 | Power-up wait in progress |
| req_err_o | output | 1 | Sticky flag: conversion request refused during a wait |

## Verification
Every state decodes to a distinct pattern of the two enables, ready and the two busy flags. A wrong state therefore shows at the ports in the cycle after the edge that caused it.

A wrong wait counter shows up as a busy window one cycle too short or too long, so the bench counts those windows cycle by cycle. It also places a refused request at every offset inside each window. A lost or leaked unlock only shows on a later conversion or chip-select edge, so every register write is followed by a cycle that exercises that bit.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [2:0] {
        ST_ACQ,
        ST_CNV,
        ST_NAP,
        ST_WAKE,
        ST_PD,
        ST_PWRUP
    } pwr_state_e;

endpackage

// File: rtl/adc_pwr_edge.sv
module adc_pwr_edge #(
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= IDLE_LVL;
        end else begin
            prev_q <= sig_i;
        end
    end

    assign rise_o = sig_i & ~prev_q;
    assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/adc_pwr_cfg.sv
module adc_pwr_cfg #(
    parameter int unsigned        ADDR_W    = 12,
    parameter int unsigned        DATA_W    = 8,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 'h010,
    parameter logic [ADDR_W-1:0]  KEY_ADDR  = 'h011,
    parameter logic [DATA_W-1:0]  KEY_VAL   = 'h69,
    parameter int unsigned        PDWN_BIT  = 0,
    parameter int unsigned        NAP_BIT   = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              nap_en_o,
    output logic              pdwn_o
);
    logic unlock_q;
    logic key_hit;
    logic ctrl_hit;

    assign key_hit  = (wr_addr_i == KEY_ADDR) && (wr_data_i == KEY_VAL);
    assign ctrl_hit = (wr_addr_i == CTRL_ADDR) && unlock_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            unlock_q <= 1'b0;
            nap_en_o <= 1'b0;
            pdwn_o   <= 1'b0;
        end else if (wr_en_i) begin
            // every write consumes the unlock; only the key write re-arms it
            unlock_q <= key_hit;
            if (ctrl_hit) begin
                pdwn_o   <= wr_data_i[PDWN_BIT];
                nap_en_o <= wr_data_i[NAP_BIT];
            end
        end
    end
endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned NAP_WAKE_CYC = 4,
    parameter int unsigned PWRUP_CYC    = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              convst_i,
    input  logic              cs_n_i,
    input  logic              eoc_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              ana_core_en_o,
    output logic              ana_aux_en_o,
    output logic              ready_o,
    output logic              wake_busy_o,
    output logic              pwrup_busy_o,
    output logic              req_err_o
);
    localparam int unsigned WAIT_MAX = (NAP_WAKE_CYC > PWRUP_CYC) ? NAP_WAKE_CYC : PWRUP_CYC;
    localparam int unsigned CNT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [CNT_W-1:0] WAKE_LOAD  = CNT_W'(NAP_WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] PWRUP_LOAD = CNT_W'(PWRUP_CYC - 1);

    pwr_state_e       st_q, st_nxt;
    logic             cv_rise, cv_fall;
    logic             cs_rise, cs_fall;
    logic             nap_en, pdwn;
    logic             tmr_load, tmr_run, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             err_set;
    logic             err_q;

    adc_pwr_edge #(.IDLE_LVL(1'b0)) i_cv_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sig_i  (convst_i),
        .rise_o (cv_rise),
        .fall_o (cv_fall)
    );

    adc_pwr_edge #(.IDLE_LVL(1'b1)) i_cs_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sig_i  (cs_n_i),
        .rise_o (cs_rise),
        .fall_o (cs_fall)
    );

    adc_pwr_cfg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .nap_en_o  (nap_en),
        .pdwn_o    (pdwn)
    );

    adc_pwr_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (tmr_run),
        .done_o     (tmr_done)
    );

    // next-state logic
    always_comb begin
        st_nxt   = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        err_set  = 1'b0;
        unique case (st_q)
            ST_ACQ: begin
                if (pdwn && cs_rise) begin
                    st_nxt = ST_PD;
                end else if (cv_rise) begin
                    st_nxt = ST_CNV;
                end
            end
            ST_CNV: begin
                if (eoc_i) begin
                    st_nxt = (nap_en && convst_i) ? ST_NAP : ST_ACQ;
                end
            end
            ST_NAP: begin
                if (cv_fall) begin
                    st_nxt   = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = WAKE_LOAD;
                end
            end
            ST_WAKE: begin
                err_set = cv_rise;
                if (tmr_done) begin
                    st_nxt = ST_ACQ;
                end
            end
            ST_PD: begin
                if (!pdwn) begin
                    st_nxt   = ST_PWRUP;
                    tmr_load = 1'b1;
                    tmr_val  = PWRUP_LOAD;
                end
            end
            ST_PWRUP: begin
                err_set = cv_rise;
                if (tmr_done) begin
                    st_nxt = ST_ACQ;
                end
            end
            default: st_nxt = ST_ACQ;
        endcase
    end

    assign tmr_run = (st_q == ST_WAKE) || (st_q == ST_PWRUP);

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= ST_ACQ;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_nxt;
            err_q <= err_q | err_set;
        end
    end

    // output decode
    always_comb begin
        ana_core_en_o = 1'b1;
        ana_aux_en_o  = 1'b1;
        ready_o       = 1'b1;
        wake_busy_o   = 1'b0;
        pwrup_busy_o  = 1'b0;
        unique case (st_q)
            ST_ACQ:   ;
            ST_CNV:   ready_o = 1'b0;
            ST_NAP:   ana_aux_en_o = 1'b0;
            ST_WAKE:  wake_busy_o = 1'b1;
            ST_PD: begin
                ana_core_en_o = 1'b0;
                ana_aux_en_o  = 1'b0;
            end
            ST_PWRUP: pwrup_busy_o = 1'b1;
            default:  ;
        endcase
    end

    assign req_err_o = err_q;

    logic unused_ok;
    assign unused_ok = cs_fall;
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
    input logic clk_i,
    input logic rst_i,
    input logic convst_i,
    input logic cs_n_i,
    input logic ana_core_en_o,
    input logic ana_aux_en_o,
    input logic ready_o,
    input logic wake_busy_o,
    input logic pwrup_busy_o,
    input logic req_err_o
);
    a_r2_request_starts_conv: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(convst_i) && ready_o && ana_aux_en_o && !wake_busy_o && !pwrup_busy_o && !$rose(cs_n_i))
        |=> !ready_o);

    a_r6_wake_follows_nap: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wake_busy_o) |-> $past(!ana_aux_en_o && ana_core_en_o));

    a_r8_pd_on_cs_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ana_core_en_o) |-> ($past(cs_n_i) && !$past(cs_n_i, 2)));

    a_r8_pd_outputs: assert property (@(posedge clk_i) disable iff (rst_i)
        !ana_core_en_o |-> (!ana_aux_en_o && ready_o));

    a_r10_pwrup_follows_pd: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pwrup_busy_o) |-> $past(!ana_core_en_o));

    a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        req_err_o |=> req_err_o);

    a_r11_err_on_early_req: assert property (@(posedge clk_i) disable iff (rst_i)
        ((wake_busy_o || pwrup_busy_o) && $rose(convst_i)) |=> req_err_o);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk i_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .convst_i      (convst_i),
    .cs_n_i        (cs_n_i),
    .ana_core_en_o (ana_core_en_o),
    .ana_aux_en_o  (ana_aux_en_o),
    .ready_o       (ready_o),
    .wake_busy_o   (wake_busy_o),
    .pwrup_busy_o  (pwrup_busy_o),
    .req_err_o     (req_err_o)
);

// File: tb/test_adc_pwr_seq.sv
module test_adc_pwr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int W_CYC  = 4;
    localparam int P_CYC  = 8;
    localparam logic [ADDR_W-1:0] A_CTRL = 12'h010;
    localparam logic [ADDR_W-1:0] A_KEY  = 12'h011;
    localparam logic [DATA_W-1:0] KEY    = 8'h69;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic convst = 1'b0, cs_n = 1'b1, eoc = 1'b0, wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic core_en, aux_en, ready, wake_busy, pwrup_busy, req_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pwr_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .NAP_WAKE_CYC(W_CYC), .PWRUP_CYC(P_CYC)
    ) i_adc_pwr_seq (
        .clk_i(clk), .rst_i(rst), .convst_i(convst), .cs_n_i(cs_n), .eoc_i(eoc),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .ana_core_en_o(core_en), .ana_aux_en_o(aux_en), .ready_o(ready),
        .wake_busy_o(wake_busy), .pwrup_busy_o(pwrup_busy), .req_err_o(req_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        convst = 0; cs_n = 1; eoc = 0; wr_en = 0;
        rst = 1;
        tick(); tick();
        rst = 0;
        tick();
    endtask

    task automatic reg_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic ctrl_wr(input logic [DATA_W-1:0] d);
        reg_wr(A_KEY, KEY);
        reg_wr(A_CTRL, d);
    endtask

    // start a conversion, then finish it with convst at the given level
    task automatic run_conv(input logic lvl_at_eoc, input string req);
        convst = 0; tick();
        convst = 1; tick();
        check({req, " conv started"}, ready, 0);
        tick();
        check({req, " still converting"}, ready, 0);
        convst = lvl_at_eoc; eoc = 1;
        tick();
        eoc = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int busy_n;
        // R1 reset state
        do_reset();
        check("R1 core", core_en, 1);
        check("R1 aux", aux_en, 1);
        check("R1 ready", ready, 1);
        check("R1 wake", wake_busy, 0);
        check("R1 pwrup", pwrup_busy, 0);
        check("R1 err", req_err, 0);

        // R2/R3 nap disabled after reset; convst high at eoc
        run_conv(1'b1, "R2");
        check("R3 ready back", ready, 1);
        check("R3 aux on", aux_en, 1);
        tick();
        check("R3 no nap", aux_en, 1);

        // R7 write without unlock is ignored
        cs_n = 0;
        reg_wr(A_CTRL, 8'h03);
        cs_n = 1; tick();
        check("R7 no pd without unlock", core_en, 1);
        run_conv(1'b1, "R7");
        check("R7 nap bit unchanged", aux_en, 1);
        // R7 intervening write consumes the unlock
        cs_n = 0;
        reg_wr(A_KEY, KEY);
        reg_wr(12'h012, 8'h00);
        reg_wr(A_CTRL, 8'h03);
        cs_n = 1; tick();
        check("R7 unlock consumed", core_en, 1);
        run_conv(1'b1, "R7");
        check("R7 unlock consumed nap", aux_en, 1);
        // R7 wrong key value does not unlock
        reg_wr(A_KEY, 8'h68);
        reg_wr(A_CTRL, 8'h02);
        run_conv(1'b1, "R7");
        check("R7 wrong key", aux_en, 1);

        // R5 nap enabled but convst low at eoc
        ctrl_wr(8'h02);
        run_conv(1'b0, "R5");
        check("R5 aux", aux_en, 1);
        check("R5 no wake", wake_busy, 0);
        tick();
        check("R5 stays acquire", wake_busy, 0);

        // R4/R6/R11 sweep of request offset inside the wake-up wait (-1: none)
        for (int k = -1; k < W_CYC; k++) begin
            do_reset();
            ctrl_wr(8'h02);
            run_conv(1'b1, "R4");
            check("R4 aux off", aux_en, 0);
            check("R4 core on", core_en, 1);
            check("R4 ready", ready, 1);
            tick(); tick();
            check("R4 nap held", aux_en, 0);
            convst = 0;
            busy_n = 0;
            for (int c = 0; c < W_CYC + 4; c++) begin
                tick();
                if (wake_busy) begin
                    if (busy_n == k) convst = 1;
                    busy_n++;
                end
            end
            check("R6 wake length", busy_n, W_CYC);
            check("R6 aux restored", aux_en, 1);
            check("R11 err flag", req_err, (k >= 0) ? 1 : 0);
            check("R11 no conversion", ready, 1);
            convst = 0; tick();
            convst = 1; tick();
            check("R2 conv after wake", ready, 0);
            check("R11 err sticky", req_err, (k >= 0) ? 1 : 0);
        end

        // R8/R9/R10/R11 sweep of request offset inside the power-up wait
        for (int k = -1; k < P_CYC; k++) begin
            do_reset();
            cs_n = 0;
            ctrl_wr(8'h03);
            tick();
            check("R8 no pd before cs edge", core_en, 1);
            cs_n = 1; tick();
            check("R8 core off", core_en, 0);
            check("R8 aux off", aux_en, 0);
            check("R8 ready", ready, 1);
            convst = 1; tick();
            convst = 0; tick();
            check("R9 convst ignored", core_en, 0);
            check("R9 no err", req_err, 0);
            reg_wr(A_CTRL, 8'h02);
            tick();
            check("R7 locked in pd", core_en, 0);
            ctrl_wr(8'h02);
            busy_n = 0;
            for (int c = 0; c < P_CYC + 4; c++) begin
                tick();
                if (pwrup_busy) begin
                    check("R10 ready in pwrup", ready, 1);
                    check("R10 core in pwrup", core_en, 1);
                    if (busy_n == k) convst = 1;
                    busy_n++;
                end
            end
            check("R10 pwrup length", busy_n, P_CYC);
            check("R11 err flag", req_err, (k >= 0) ? 1 : 0);
            check("R11 no conversion", ready, 1);
            // R9 nap enable kept through power cycle
            run_conv(1'b1, "R9");
            check("R9 nap kept", aux_en, 0);
            convst = 0;
            for (int c = 0; c < W_CYC + 2; c++) tick();
        end

        summary();
    end
endmodule